// File: doc/BRIEF.md
# Lockable Cartridge Bank Register

This block is the host-facing control register of a plug-in ROM card that sits on an expansion bus. The bus carries two active-low ROM window strobes and two active-low I/O window strobes. A host write in the first I/O window loads three fields into the register: a bank select bit, a memory-map control value, and a lock bit. The memory-map control value drives two mapping lines that always move together.

Setting the lock bit makes the register ignore every later write in the first I/O window until the next reset. The block builds the ROM address by placing the bank bit above the host offset. It enables the ROM and drives the host data bus during ROM window reads. It also routes writes in the second I/O window to a mailbox latch outside the block, and drives that latch's read data during reads in the second I/O window.

Top module: `cbank_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, the bank bit, both mapping lines and the lock flag are 0.
- R2: A clock edge with `host_wr`=1, `io1_n`=0 and the lock flag clear loads the register from `host_din`. Bit 0 goes to the bank bit, bit 1 to the mapping lines and bit 7 to the lock flag. The new values are visible after that edge.
- R3: `map_line0` and `map_line1` both take the value of `host_din` bit 1 on each accepted register write.
- R4: Once the lock flag is set, writes with `io1_n`=0 leave the bank bit, the mapping lines and the lock flag unchanged until reset.
- R5: `rom_addr` equals the bank bit in bit 14, with `host_offs[13:0]` in bits 13..0.
- R6: When `host_rd`=1 and either `rom_lo_n` or `rom_hi_n` is 0, `rom_ce_n`=0, `host_doe`=1 and `host_dout`=`rom_rdata`. In every other case `rom_ce_n`=1.
- R7: When `host_rd`=1, both ROM strobes are high and `io2_n`=0, `host_doe`=1 and `host_dout`=`mbox_rdata`.
- R8: When a read has a ROM strobe and `io2_n` low together, the ROM data wins.
- R9: When neither R6 nor R7 applies, `host_doe`=0 and `host_dout`=`host_din`.
- R10: `mbox_wr`=1 exactly when `host_wr`=1, `io2_n`=0, and either the lock flag is set or `io1_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_offs | input | 14 | Host address offset |
| host_rd | input | 1 | Host read cycle |
| host_wr | input | 1 | Host write cycle |
| rom_lo_n | input | 1 | Lower ROM window strobe, active low |
| rom_hi_n | input | 1 | Upper ROM window strobe, active low |
| io1_n | input | 1 | First I/O window strobe, active low |
| io2_n | input | 1 | Second I/O window strobe, active low |
| host_din | input | 8 | Host bus data into the card |
| host_dout | output | 8 | Host bus data out of the card |
| host_doe | output | 1 | Card drives the host data bus |
| rom_addr | output | 15 | ROM address |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_rdata | input | 8 | ROM read data |
| map_line0 | output | 1 | First memory-map control line |
| map_line1 | output | 1 | Second memory-map control line |
| mbox_wr | output | 1 | Write strobe to the mailbox latch |
| mbox_rdata | input | 8 | Mailbox latch read data |

## Verification
The hardest state to reach is the locked register, because the lock flag has no port of its own. The bench sets it through a write in the first I/O window with bit 7 high. It then shows that later writes have no effect by watching bank bit 14 of `rom_addr` and the mapping lines stay put. It also shows that a write with both I/O strobes low now goes to the mailbox. A second reset followed by a write proves that the lock is released. A run of random bus cycles, checked against the reference model, then mixes locked and unlocked traffic with overlapping strobes.

// File: rtl/cbank_pkg.sv
package cbank_pkg;
    typedef struct packed {
        logic bank;
        logic map;
        logic hide;
    } ctrl_t;
endpackage

// File: rtl/cbank_ctrl_reg.sv
module cbank_ctrl_reg
    import cbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_sel,
    input  ctrl_t wr_val,
    output ctrl_t ctrl_q,
    output logic  accept
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        accept = wr_sel && !ctrl_q.hide;
        if (accept) begin
            ctrl_d = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/cbank_addr.sv
module cbank_addr #(
    parameter int OFFS_W = 14
) (
    input  logic              bank,
    input  logic [OFFS_W-1:0] offs,
    input  logic              rd,
    input  logic              rom_lo_n,
    input  logic              rom_hi_n,
    output logic [OFFS_W:0]   addr,
    output logic              rom_hit,
    output logic              ce_n
);
    always_comb begin
        addr    = {bank, offs};
        rom_hit = rd && (!rom_lo_n || !rom_hi_n);
        ce_n    = !rom_hit;
    end
endmodule

// File: rtl/cbank_bus.sv
module cbank_bus #(
    parameter int DATA_W = 8
) (
    input  logic              rd,
    input  logic              wr,
    input  logic              rom_hit,
    input  logic              io2_n,
    input  logic              reg_accept,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] mbox_rdata,
    output logic [DATA_W-1:0] dout,
    output logic              doe,
    output logic              mbox_wr
);
    always_comb begin
        dout    = din;
        doe     = 1'b0;
        if (rom_hit) begin
            dout = rom_rdata;
            doe  = 1'b1;
        end else if (rd && !io2_n) begin
            dout = mbox_rdata;
            doe  = 1'b1;
        end
        mbox_wr = wr && !io2_n && !reg_accept;
    end
endmodule

// File: rtl/cbank_top.sv
module cbank_top
    import cbank_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OFFS_W   = 14,
    parameter int BANK_BIT = 0,
    parameter int MAP_BIT  = 1,
    parameter int HIDE_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFFS_W-1:0] host_offs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              rom_lo_n,
    input  logic              rom_hi_n,
    input  logic              io1_n,
    input  logic              io2_n,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    output logic [OFFS_W:0]   rom_addr,
    output logic              rom_ce_n,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              map_line0,
    output logic              map_line1,
    output logic              mbox_wr,
    input  logic [DATA_W-1:0] mbox_rdata
);
    ctrl_t wr_val;
    ctrl_t ctrl_q;
    logic  reg_accept;
    logic  rom_hit;
    logic  hide_q;

    always_comb begin
        wr_val.bank = host_din[BANK_BIT];
        wr_val.map  = host_din[MAP_BIT];
        wr_val.hide = host_din[HIDE_BIT];
        hide_q      = ctrl_q.hide;
        map_line0   = ctrl_q.map;
        map_line1   = ctrl_q.map;
    end

    cbank_ctrl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (host_wr && !io1_n),
        .wr_val (wr_val),
        .ctrl_q (ctrl_q),
        .accept (reg_accept)
    );

    cbank_addr #(.OFFS_W(OFFS_W)) u_addr (
        .bank     (ctrl_q.bank),
        .offs     (host_offs),
        .rd       (host_rd),
        .rom_lo_n (rom_lo_n),
        .rom_hi_n (rom_hi_n),
        .addr     (rom_addr),
        .rom_hit  (rom_hit),
        .ce_n     (rom_ce_n)
    );

    cbank_bus #(.DATA_W(DATA_W)) u_bus (
        .rd         (host_rd),
        .wr         (host_wr),
        .rom_hit    (rom_hit),
        .io2_n      (io2_n),
        .reg_accept (reg_accept),
        .din        (host_din),
        .rom_rdata  (rom_rdata),
        .mbox_rdata (mbox_rdata),
        .dout       (host_dout),
        .doe        (host_doe),
        .mbox_wr    (mbox_wr)
    );
endmodule

// File: rtl/cbank_top_chk.sv
module cbank_top_chk #(
    parameter int DATA_W   = 8,
    parameter int BANK_BIT = 0,
    parameter int MAP_BIT  = 1,
    parameter int HIDE_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_rd,
    input logic              host_wr,
    input logic              rom_lo_n,
    input logic              rom_hi_n,
    input logic              io1_n,
    input logic              io2_n,
    input logic [DATA_W-1:0] host_din,
    input logic [DATA_W-1:0] host_dout,
    input logic              host_doe,
    input logic              rom_bank,
    input logic              rom_ce_n,
    input logic [DATA_W-1:0] rom_rdata,
    input logic              map_line0,
    input logic              map_line1,
    input logic              mbox_wr,
    input logic [DATA_W-1:0] mbox_rdata,
    input logic              hide_q
);
    assert_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !io1_n && !hide_q) |=>
        (rom_bank == $past(host_din[BANK_BIT]) && map_line0 == $past(host_din[MAP_BIT])
         && hide_q == $past(host_din[HIDE_BIT])));

    assert_map_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !io1_n && !hide_q) |=> (map_line1 == $past(host_din[MAP_BIT])));

    assert_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hide_q |=> (hide_q && $stable(rom_bank) && $stable(map_line0) && $stable(map_line1)));

    assert_rom_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (!rom_lo_n || !rom_hi_n)) |-> (!rom_ce_n && host_doe && host_dout == rom_rdata));

    assert_mbox_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && rom_lo_n && rom_hi_n && !io2_n) |-> (host_doe && host_dout == mbox_rdata));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && (!rom_lo_n || !rom_hi_n || !io2_n)) |-> (!host_doe && rom_ce_n && host_dout == host_din));

    assert_mbox_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !io2_n) |-> (mbox_wr == (hide_q || io1_n)));
endmodule

bind cbank_top cbank_top_chk #(
    .DATA_W(DATA_W), .BANK_BIT(BANK_BIT), .MAP_BIT(MAP_BIT), .HIDE_BIT(HIDE_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .rom_lo_n(rom_lo_n), .rom_hi_n(rom_hi_n), .io1_n(io1_n), .io2_n(io2_n),
    .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
    .rom_bank(rom_addr[OFFS_W]), .rom_ce_n(rom_ce_n), .rom_rdata(rom_rdata),
    .map_line0(map_line0), .map_line1(map_line1), .mbox_wr(mbox_wr),
    .mbox_rdata(mbox_rdata), .hide_q(hide_q)
);

// File: tb/cbank_top_test.sv
`timescale 1ns/1ps
module cbank_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] host_offs = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic        rom_lo_n = 1'b1, rom_hi_n = 1'b1, io1_n = 1'b1, io2_n = 1'b1;
    logic [7:0]  host_din = '0, rom_rdata = '0, mbox_rdata = '0;
    logic [7:0]  host_dout;
    logic        host_doe, rom_ce_n, map_line0, map_line1, mbox_wr;
    logic [14:0] rom_addr;

    int checks = 0, fails = 0;
    bit m_bank = 0, m_map = 0, m_hide = 0;

    always #4 clk = ~clk;

    cbank_top uut (
        .clk(clk), .rst_n(rst_n), .host_offs(host_offs), .host_rd(host_rd),
        .host_wr(host_wr), .rom_lo_n(rom_lo_n), .rom_hi_n(rom_hi_n),
        .io1_n(io1_n), .io2_n(io2_n), .host_din(host_din), .host_dout(host_dout),
        .host_doe(host_doe), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
        .rom_rdata(rom_rdata), .map_line0(map_line0), .map_line1(map_line1),
        .mbox_wr(mbox_wr), .mbox_rdata(mbox_rdata)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit    rom_act;
        string rq, sq;
        if (!rst_n) begin m_bank = 0; m_map = 0; m_hide = 0; end
        rom_act = host_rd && (!rom_lo_n || !rom_hi_n);
        sq = !rst_n ? "R1" : (m_hide ? "R4" : "R2");
        chk(sq, "bank bit", int'(rom_addr[14]), int'(m_bank));
        chk(sq, "map_line0", int'(map_line0), int'(m_map));
        chk(!rst_n ? "R1" : "R3", "map_line1", int'(map_line1), int'(m_map));
        chk("R5", "rom_addr low", int'(rom_addr[13:0]), int'(host_offs));
        chk("R6", "rom_ce_n", int'(rom_ce_n), int'(!rom_act));
        if (rom_act) begin
            rq = !io2_n ? "R8" : "R6";
            chk(rq, "doe", int'(host_doe), 1);
            chk(rq, "dout", int'(host_dout), int'(rom_rdata));
        end else if (host_rd && !io2_n) begin
            chk("R7", "doe", int'(host_doe), 1);
            chk("R7", "dout", int'(host_dout), int'(mbox_rdata));
        end else begin
            chk("R9", "doe", int'(host_doe), 0);
            chk("R9", "dout", int'(host_dout), int'(host_din));
        end
        chk("R10", "mbox_wr", int'(mbox_wr),
            int'(host_wr && !io2_n && (m_hide || io1_n)));
    endtask

    task automatic step(bit rs, bit rd, bit wr, bit rl, bit rh, bit i1, bit i2,
                        logic [13:0] offs, logic [7:0] din);
        @(negedge clk);
        rst_n = rs; host_rd = rd; host_wr = wr; rom_lo_n = rl; rom_hi_n = rh;
        io1_n = i1; io2_n = i2; host_offs = offs; host_din = din;
        rom_rdata = 8'($urandom); mbox_rdata = 8'($urandom);
        #2;
        compare();
        @(posedge clk);
        if (rst_n && host_wr && !io1_n && !m_hide) begin
            m_bank = din[0]; m_map = din[1]; m_hide = din[7];
        end
    endtask

    initial begin
        #(8ns * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(0, 0, 1, 1, 1, 0, 1, 14'h0, 8'hff);          // R1: write ignored in reset
        step(0, 1, 0, 0, 1, 1, 1, 14'h0123, 8'h00);
        step(1, 1, 0, 0, 1, 1, 1, 14'h1234, 8'h5a);       // R6 ROM read bank 0
        step(1, 0, 1, 1, 1, 0, 1, 14'h0, 8'h03);          // R2 write bank=1 map=1
        step(1, 1, 0, 1, 0, 1, 1, 14'h3fff, 8'h11);       // R5 addr 0x7fff
        step(1, 1, 0, 1, 1, 1, 0, 14'h0042, 8'h22);       // R7 mailbox read
        step(1, 1, 0, 0, 0, 1, 0, 14'h0100, 8'h33);       // R8 ROM over io2
        step(1, 0, 1, 1, 1, 0, 0, 14'h0, 8'h02);          // R10 both io low, unlocked
        step(1, 0, 1, 1, 1, 1, 0, 14'h0, 8'h44);          // R10 mailbox write
        step(1, 0, 1, 1, 1, 0, 1, 14'h0, 8'h80);          // lock, bank 0 map 0
        step(1, 0, 1, 1, 1, 0, 1, 14'h0, 8'h03);          // R4 ignored
        step(1, 0, 1, 1, 1, 0, 0, 14'h0, 8'h03);          // R4/R10 locked
        step(1, 1, 0, 1, 1, 1, 1, 14'h2222, 8'h66);       // R9 no strobe
        step(1, 0, 0, 0, 0, 1, 0, 14'h2222, 8'h77);       // R9 strobes without read
        step(0, 0, 0, 1, 1, 1, 1, 14'h0, 8'h00);          // R1 reset again
        step(1, 0, 1, 1, 1, 0, 1, 14'h0, 8'h02);          // unlocked after reset
        step(1, 0, 0, 1, 1, 1, 1, 14'h0, 8'h00);
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 50) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 14'($urandom), 8'($urandom));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule